// File: doc/BRIEF.md
# Interrupt Mask and Stop-Inhibit Control

This block keeps two special bits of an 8-bit processor's flags register: the mask that blocks the non-maskable interrupt, and the bit that stops the stop instruction from entering low power. Reset sets both bits. After that, only hardware can raise the interrupt mask, by acknowledging a non-maskable interrupt. Only software can lower it, through one of two flag-loading instructions. One copies the accumulator into the flags. The other restores the flags from the stack when returning from an interrupt. Each of these loads copies the stop-inhibit bit straight from the loaded byte.

The decoder pulses one strobe per instruction of interest and presents the byte being loaded. The block answers a stop instruction in the same cycle. It either requests low-power entry or marks the stop as a no-operation, so that execution goes on with the next instruction. The other flags, the stack logic and the clock gating sit outside this block.

Top module: `cpu_mask_guard`

## Requirements
- R1: After reset, `nmi_mask` reads 1 and `stop_inhibit` reads 1.
- R2: A cycle with `nmi_ack` high leaves `nmi_mask` at 1 after the next rising clock edge.
- R3: When `nmi_ack` is low, a flag load (`load_acc` or `load_ret`) whose byte has bit 6 equal to 0 leaves `nmi_mask` at 0 after the edge.
- R4: A flag load whose byte has bit 6 equal to 1 never raises `nmi_mask` from 0; it stays 0.
- R5: When `nmi_ack` and a clearing flag load occur in the same cycle, `nmi_mask` ends at 1.
- R6: No event other than a clearing flag load lowers `nmi_mask`. This includes stop strobes, byte changes without a strobe, and `nmi_ack`.
- R7: Either flag load copies bit 7 of `load_byte` into `stop_inhibit` at the edge.
- R8: While `stop_inhibit` is 1, a `stop_exec` cycle drives `stop_nop` high and `stop_req` low in that same cycle.
- R9: While `stop_inhibit` is 0, a `stop_exec` cycle drives `stop_req` high and `stop_nop` low in that cycle only. Both are low in any cycle without `stop_exec`.
- R10: `stop_inhibit` does not change without a flag load. It ignores `nmi_ack`, stop strobes and changes of `load_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_ack | input | 1 | Hardware acknowledge of a non-maskable interrupt |
| load_acc | input | 1 | Strobe: accumulator copied into the flags |
| load_ret | input | 1 | Strobe: flags restored on return from interrupt |
| load_byte | input | 8 | Byte being loaded into the flags |
| stop_exec | input | 1 | Strobe: stop instruction decoded |
| nmi_mask | output | 1 | Current interrupt-mask bit |
| stop_inhibit | output | 1 | Current stop-inhibit bit |
| stop_req | output | 1 | Enter low power this cycle |
| stop_nop | output | 1 | Stop treated as no-operation this cycle |

## Verification
The hardest state to reach is a clearing load that meets an acknowledge in the same cycle. A second hard case is a load that tries to set the mask after software has already cleared it. The stimulus table first lowers the mask with a return-load and then offers loads with bit 6 set. Only after that does it pair acknowledges with clearing loads of both kinds. Stop behaviour is tested with the inhibit bit in both states, reached by loading bit 7 through each path.

// File: rtl/cpu_mask_pkg.sv
package cpu_mask_pkg;
  localparam int FLAG_W   = 8;
  localparam int MASK_POS = 6;
  localparam int INH_POS  = 7;

  // Mask update: hardware set dominates, software may only clear.
  function automatic logic mask_next(input logic cur, input logic hw_set,
                                     input logic sw_load, input logic load_bit);
    logic nxt;
    nxt = cur;
    if (sw_load && !load_bit) nxt = 1'b0;
    if (hw_set) nxt = 1'b1;
    return nxt;
  endfunction

  // Inhibit update: direct copy on a load, otherwise hold.
  function automatic logic inhibit_next(input logic cur, input logic sw_load,
                                        input logic load_bit);
    return sw_load ? load_bit : cur;
  endfunction
endpackage

// File: rtl/mask_hold_reg.sv
module mask_hold_reg
  import cpu_mask_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_load,
  input  logic load_bit,
  output logic mask_q
);
  logic clr_evt;
  logic mask_d;

  assign clr_evt = sw_load && !load_bit;
  assign mask_d  = mask_next(mask_q, hw_set, sw_load, load_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b1;
    else        mask_q <= mask_d;
  end

  a_r2_ack_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> mask_q);
  a_r3_load_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !hw_set) |=> !mask_q);
  a_r4_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q && !hw_set) |=> !mask_q);
  a_r6_only_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !clr_evt) |=> mask_q);
endmodule

// File: rtl/inhibit_hold_reg.sv
module inhibit_hold_reg
  import cpu_mask_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_load,
  input  logic load_bit,
  output logic inh_q
);
  logic inh_d;
  assign inh_d = inhibit_next(inh_q, sw_load, load_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_q <= 1'b1;
    else        inh_q <= inh_d;
  end

  a_r7_load_copies_bit: assert property (@(posedge clk) disable iff (!rst_n)
    sw_load |=> (inh_q == $past(load_bit)));
  a_r10_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_load |=> $stable(inh_q));
endmodule

// File: rtl/stop_arbiter.sv
module stop_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_exec,
  input  logic inhibit,
  output logic stop_req,
  output logic stop_nop
);
  assign stop_req = stop_exec && !inhibit;
  assign stop_nop = stop_exec &&  inhibit;

  a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_req, stop_nop}));
  a_r8_r9_answered: assert property (@(posedge clk) disable iff (!rst_n)
    stop_exec |-> (stop_req || stop_nop));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_exec |-> !(stop_req || stop_nop));
endmodule

// File: rtl/cpu_mask_guard.sv
module cpu_mask_guard
  import cpu_mask_pkg::*;
#(
  parameter int DATA_W = FLAG_W,
  parameter int M_POS  = MASK_POS,
  parameter int I_POS  = INH_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_ack,
  input  logic              load_acc,
  input  logic              load_ret,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              stop_exec,
  output logic              nmi_mask,
  output logic              stop_inhibit,
  output logic              stop_req,
  output logic              stop_nop
);
  logic any_load;
  logic mask_bit;
  logic inh_bit;

  assign any_load = load_acc || load_ret;
  assign mask_bit = load_byte[M_POS];
  assign inh_bit  = load_byte[I_POS];

  mask_hold_reg u_mask (
    .clk(clk), .rst_n(rst_n), .hw_set(nmi_ack),
    .sw_load(any_load), .load_bit(mask_bit), .mask_q(nmi_mask)
  );

  inhibit_hold_reg u_inh (
    .clk(clk), .rst_n(rst_n), .sw_load(any_load),
    .load_bit(inh_bit), .inh_q(stop_inhibit)
  );

  stop_arbiter u_stop (
    .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec),
    .inhibit(stop_inhibit), .stop_req(stop_req), .stop_nop(stop_nop)
  );

  a_r5_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ack && any_load && !mask_bit) |=> nmi_mask);
endmodule

// File: tb/cpu_mask_guard_test.sv
module cpu_mask_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_ack = 1'b0, load_acc = 1'b0, load_ret = 1'b0, stop_exec = 1'b0;
  logic [7:0] load_byte = 8'h00;
  logic nmi_mask, stop_inhibit, stop_req, stop_nop;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cpu_mask_guard uut (
    .clk(clk), .rst_n(rst_n), .nmi_ack(nmi_ack), .load_acc(load_acc),
    .load_ret(load_ret), .load_byte(load_byte), .stop_exec(stop_exec),
    .nmi_mask(nmi_mask), .stop_inhibit(stop_inhibit),
    .stop_req(stop_req), .stop_nop(stop_nop)
  );

  // {req, ack, load_acc, load_ret, stop, byte, exp_req, exp_nop, exp_mask, exp_inh}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {4'd8,  4'b0001, 8'h00, 4'b0111},  // R8 stop while inhibited
    {4'd7,  4'b0100, 8'h40, 4'b0010},  // R7 acc load clears inhibit, mask kept
    {4'd9,  4'b0001, 8'h00, 4'b1010},  // R9 stop enters low power
    {4'd9,  4'b0000, 8'h00, 4'b0010},  // R9 request lasts one cycle
    {4'd3,  4'b0010, 8'h80, 4'b0001},  // R3 return load clears mask
    {4'd4,  4'b0010, 8'hC0, 4'b0001},  // R4 return load cannot set mask
    {4'd4,  4'b0100, 8'h40, 4'b0000},  // R4 acc load cannot set mask
    {4'd10, 4'b0000, 8'hFF, 4'b0000},  // R10 byte change without strobe
    {4'd2,  4'b1000, 8'h00, 4'b0010},  // R2 acknowledge sets mask
    {4'd5,  4'b1100, 8'h00, 4'b0010},  // R5 ack beats acc clear
    {4'd5,  4'b1010, 8'h80, 4'b0011},  // R5 ack beats return clear
    {4'd6,  4'b0001, 8'h00, 4'b0111},  // R6 stop leaves mask
    {4'd3,  4'b0100, 8'h80, 4'b0001},  // R3 acc load clears mask
    {4'd2,  4'b1001, 8'h00, 4'b0111}   // R2 ack with inhibited stop
  };

  task automatic chk(input string what, input int req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("mask in reset", 1, nmi_mask, 1'b1);
    chk("inhibit in reset", 1, stop_inhibit, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("mask after reset", 1, nmi_mask, 1'b1);
    chk("inhibit after reset", 1, stop_inhibit, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      int rq;
      v = VEC[i];
      rq = int'(v[19:16]);
      {nmi_ack, load_acc, load_ret, stop_exec} = v[15:12];
      load_byte = v[11:4];
      #1;
      chk($sformatf("vec %0d stop_req", i), rq, stop_req, v[3]);
      chk($sformatf("vec %0d stop_nop", i), rq, stop_nop, v[2]);
      @(negedge clk);
      {nmi_ack, load_acc, load_ret, stop_exec} = 4'b0000;
      #1;
      chk($sformatf("vec %0d mask", i), rq, nmi_mask, v[1]);
      chk($sformatf("vec %0d inhibit", i), rq, stop_inhibit, v[0]);
    end

    // R1: clear both bits, then reset restores them
    load_ret = 1'b1; load_byte = 8'h00;
    @(negedge clk);
    load_ret = 1'b0;
    chk("mask cleared before reset", 3, nmi_mask, 1'b0);
    chk("inhibit cleared before reset", 7, stop_inhibit, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("mask restored by reset", 1, nmi_mask, 1'b1);
    chk("inhibit restored by reset", 1, stop_inhibit, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: ack alone leaves inhibit after a cleared load
    load_acc = 1'b1; load_byte = 8'h00;
    @(negedge clk);
    load_acc = 1'b0; nmi_ack = 1'b1; load_byte = 8'hFF;
    @(negedge clk);
    nmi_ack = 1'b0;
    chk("inhibit ignores ack", 10, stop_inhibit, 1'b0);
    chk("ack sets mask again", 2, nmi_mask, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule